// File: doc/BRIEF.md
# Bit-Vector Coherence Directory Engine

This block is the home-side directory engine for one node of a distributed shared-memory machine with up to sixteen clusters. For each 16-byte line homed at this node, it keeps a presence bit per cluster and a dirty flag. Together these encode three line states. Uncached means no presence bits are set and the line is clean. Shared means one or more presence bits are set and the line is clean. Dirty means the line is held modified by exactly one cluster.

Coherence requests arrive on a valid/ready port. Each carries an operation (read, read-exclusive or writeback), a byte address and the requesting cluster number. The engine looks up the entry, applies the protocol transition and writes the entry back in the same cycle. One cycle after acceptance it presents a message descriptor. The descriptor is one of: a data reply, a forward to the current owner, a writeback acknowledge or a protocol error. A data reply to a read-exclusive also carries the invalidation mask and the count of invalidations issued.

The home never collects invalidation acknowledgements. The requester is told how many to expect, and an owner that receives a forward answers the requester directly. On reset the engine clears its storage, one entry per cycle, before it accepts any request.

Top module: `coh_dir_engine`

## Requirements
- R1: After reset is released, `in_ready` stays low for exactly 2^IDX_W clock edges while every entry is cleared to uncached, and it then rises. No request is accepted and `out_valid` stays low during this time.
- R2: The address is split as follows. Bits [3:0] are the byte offset within the line. Bits [7:4] are the home cluster field. Bits [7+IDX_W:8] are the entry index. A request whose home field differs from HOME_ID is accepted but produces no message and leaves the directory unchanged.
- R3: A read (op code 0) to a clean line returns kind 0 (data) to the requester. The requester's presence bit is added and the line stays clean.
- R4: A read-exclusive (op code 1) to a clean line returns kind 1 (exclusive data) to the requester. The invalidation mask is the presence vector with the requester's bit cleared, and the count equals the number of ones in that mask. The entry becomes dirty with only the requester's bit set.
- R5: A read to a line that is dirty at another cluster yields kind 2 (forward), with the destination set to the owner. The entry becomes clean with both the owner's and the requester's bits set.
- R6: A read-exclusive to a line that is dirty at another cluster yields kind 2 (forward) to the owner, with an empty mask and a zero count. Ownership moves to the requester.
- R7: A writeback (op code 2) from the recorded owner of a dirty line yields kind 3 (writeback acknowledge) to the requester, and the line becomes uncached.
- R8: The following requests yield kind 4 (error) to the requester and leave the entry unchanged: a writeback from any cluster other than the owner of a dirty line, a read or read-exclusive from the line's own owner, and op code 3.
- R9: Every accepted home request gives exactly one message, valid in the cycle after acceptance. Back-to-back requests to the same entry observe each preceding update.
- R10: Every message carries the requester in `out_src` and the line address (address bits above bit 3) in `out_line`. The mask and count are zero for all kinds except exclusive data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Engine can accept a request |
| in_op | input | 2 | 0 read, 1 read-exclusive, 2 writeback, 3 reserved |
| in_addr | input | 8+IDX_W | Byte address of the line |
| in_src | input | 4 | Requesting cluster |
| out_valid | output | 1 | Message descriptor valid (one cycle) |
| out_kind | output | 3 | 0 data, 1 exclusive data, 2 forward, 3 writeback ack, 4 error |
| out_dest | output | 4 | Cluster that must act on the message |
| out_src | output | 4 | Original requester |
| out_line | output | 4+IDX_W | Line address |
| out_inv_mask | output | 16 | Clusters to invalidate |
| out_inv_cnt | output | 5 | Number of invalidations issued |

## Verification
The hardest situation to reach from the ports is a writeback issued by the true owner of a dirty line. Random clusters almost always hit the error path instead. It is also hard to reach a read-exclusive that finds many sharers, since writebacks keep clearing lines. The stimulus addresses this by keeping a reference directory in the bench. When it chooses a writeback, it usually steers the source to the owner it has on record. The sweep is confined to eight entries across all sixteen clusters, so sharer sets build up. Requests are issued back to back with no idle cycle, and a fraction of them carry a foreign home field, which tests forwarding of fresh state and the silent drop of foreign requests.

// File: rtl/coh_dir_pkg.sv
package coh_dir_pkg;

    localparam int CLUSTERS = 16;
    localparam int CL_W     = $clog2(CLUSTERS);
    localparam int LINE_OFS = 4;
    localparam int CNT_W    = $clog2(CLUSTERS + 1);

    typedef logic [CLUSTERS-1:0] pres_t;
    typedef logic [CL_W-1:0]     cl_t;
    typedef logic [CNT_W-1:0]    cnt_t;

    typedef enum logic [1:0] {
        OP_READ = 2'd0,
        OP_RDX  = 2'd1,
        OP_WB   = 2'd2,
        OP_RSVD = 2'd3
    } op_e;

    typedef enum logic [2:0] {
        K_DATA      = 3'd0,
        K_DATA_EXCL = 3'd1,
        K_FWD       = 3'd2,
        K_WB_ACK    = 3'd3,
        K_ERR       = 3'd4
    } kind_e;

    typedef struct packed {
        logic  dirty;
        pres_t pres;
    } entry_t;

    typedef struct packed {
        kind_e kind;
        cl_t   dest;
        pres_t inv_mask;
        cnt_t  inv_cnt;
    } msg_t;

    function automatic cnt_t ones_in(input pres_t v);
        cnt_t n;
        n = '0;
        for (int i = 0; i < CLUSTERS; i++) begin
            n = n + cnt_t'(v[i]);
        end
        return n;
    endfunction

    function automatic cl_t lowest_set(input pres_t v);
        cl_t r;
        r = '0;
        for (int i = CLUSTERS - 1; i >= 0; i--) begin
            if (v[i]) r = cl_t'(i);
        end
        return r;
    endfunction

    function automatic pres_t bit_of(input cl_t c);
        return pres_t'(1) << c;
    endfunction

endpackage

// File: rtl/coh_dir_store.sv
module coh_dir_store
    import coh_dir_pkg::*;
#(
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] rd_idx,
    output entry_t           rd_entry,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  entry_t           wr_entry,
    output logic             init_done
);
    localparam int DEPTH = 1 << IDX_W;

    entry_t           mem [DEPTH];
    logic             sweeping;
    logic [IDX_W-1:0] sweep_idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            sweeping  <= 1'b1;
            sweep_idx <= '0;
        end else if (sweeping) begin
            sweep_idx <= sweep_idx + 1'b1;
            if (sweep_idx == IDX_W'(DEPTH - 1)) sweeping <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (sweeping && !rst) begin
            mem[sweep_idx] <= '0;
        end else if (wr_en) begin
            mem[wr_idx] <= wr_entry;
        end
    end

    assign rd_entry  = mem[rd_idx];
    assign init_done = !sweeping;

    // R1: the port write path is shut while the clearing sweep runs
    a_r1_no_write_in_sweep: assert property (@(posedge clk) disable iff (rst)
        sweeping |-> !wr_en);

    // R4/R6: a dirty entry always names exactly one owner
    a_r4_dirty_single_owner: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_entry.dirty) |-> $onehot(wr_entry.pres));

endmodule

// File: rtl/coh_dir_rules.sv
module coh_dir_rules
    import coh_dir_pkg::*;
(
    input  logic   act,
    input  op_e    op,
    input  cl_t    src,
    input  entry_t cur,
    output msg_t   msg,
    output entry_t nxt,
    output logic   upd
);
    pres_t req_bit;
    cl_t   owner;
    logic  owned_by_req;
    pres_t others;

    assign req_bit      = bit_of(src);
    assign owner        = lowest_set(cur.pres);
    assign owned_by_req = cur.dirty && (owner == src);
    assign others       = cur.pres & ~req_bit;

    always_comb begin
        msg.kind     = K_ERR;
        msg.dest     = src;
        msg.inv_mask = '0;
        msg.inv_cnt  = '0;
        nxt          = cur;
        upd          = 1'b0;
        unique case (op)
            OP_READ: begin
                if (!cur.dirty) begin
                    msg.kind  = K_DATA;
                    nxt.pres  = cur.pres | req_bit;
                    nxt.dirty = 1'b0;
                    upd       = 1'b1;
                end else if (!owned_by_req) begin
                    msg.kind  = K_FWD;
                    msg.dest  = owner;
                    nxt.pres  = cur.pres | req_bit;
                    nxt.dirty = 1'b0;
                    upd       = 1'b1;
                end
            end
            OP_RDX: begin
                if (!cur.dirty) begin
                    msg.kind     = K_DATA_EXCL;
                    msg.inv_mask = others;
                    msg.inv_cnt  = ones_in(others);
                    nxt.pres     = req_bit;
                    nxt.dirty    = 1'b1;
                    upd          = 1'b1;
                end else if (!owned_by_req) begin
                    msg.kind  = K_FWD;
                    msg.dest  = owner;
                    nxt.pres  = req_bit;
                    nxt.dirty = 1'b1;
                    upd       = 1'b1;
                end
            end
            OP_WB: begin
                if (owned_by_req) begin
                    msg.kind = K_WB_ACK;
                    nxt      = '0;
                    upd      = 1'b1;
                end
            end
            default: begin
                msg.kind = K_ERR;
            end
        endcase
    end

    always_comb begin
        if (act) begin
            // R4: the requester never appears in its own invalidation set
            a_r4_self_not_invalidated: assert (msg.inv_mask[src] == 1'b0);
            // R8: an error leaves the stored entry as it was
            a_r8_error_keeps_entry: assert (msg.kind != K_ERR || nxt == cur);
        end
    end

endmodule

// File: rtl/coh_dir_engine.sv
module coh_dir_engine
    import coh_dir_pkg::*;
#(
    parameter int IDX_W   = 6,
    parameter int HOME_ID = 0
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         in_valid,
    output logic                         in_ready,
    input  logic [1:0]                   in_op,
    input  logic [LINE_OFS+CL_W+IDX_W-1:0] in_addr,
    input  logic [CL_W-1:0]              in_src,
    output logic                         out_valid,
    output logic [2:0]                   out_kind,
    output logic [CL_W-1:0]              out_dest,
    output logic [CL_W-1:0]              out_src,
    output logic [CL_W+IDX_W-1:0]        out_line,
    output logic [CLUSTERS-1:0]          out_inv_mask,
    output logic [CNT_W-1:0]             out_inv_cnt
);
    localparam int LINE_W = CL_W + IDX_W;

    logic [LINE_W-1:0] line;
    logic [IDX_W-1:0]  idx;
    cl_t               home_field;
    logic              is_home;
    logic              accept;
    logic              init_done;
    entry_t            cur;
    entry_t            nxt;
    msg_t              msg;
    logic              upd;

    assign line       = in_addr[LINE_OFS +: LINE_W];
    assign home_field = line[CL_W-1:0];
    assign idx        = line[CL_W +: IDX_W];
    assign is_home    = (home_field == cl_t'(HOME_ID));
    assign in_ready   = init_done;
    assign accept     = in_valid && in_ready;

    coh_dir_store #(.IDX_W(IDX_W)) store_i (
        .clk       (clk),
        .rst       (rst),
        .rd_idx    (idx),
        .rd_entry  (cur),
        .wr_en     (accept && is_home && upd),
        .wr_idx    (idx),
        .wr_entry  (nxt),
        .init_done (init_done)
    );

    coh_dir_rules rules_i (
        .act (accept && is_home),
        .op  (op_e'(in_op)),
        .src (in_src),
        .cur (cur),
        .msg (msg),
        .nxt (nxt),
        .upd (upd)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
        end else begin
            out_valid <= accept && is_home;
        end
        if (accept && is_home) begin
            out_kind     <= msg.kind;
            out_dest     <= msg.dest;
            out_src      <= in_src;
            out_line     <= line;
            out_inv_mask <= msg.inv_mask;
            out_inv_cnt  <= msg.inv_cnt;
        end
    end

    // R9: a message only ever follows an accepted request
    a_r9_msg_follows_accept: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid && in_ready));

    // R2: a foreign-home request never produces a message
    a_r2_foreign_silent: assert property (@(posedge clk) disable iff (rst)
        (accept && !is_home) |=> !out_valid);

    // R4: count agrees with the mask it accompanies
    a_r4_cnt_matches_mask: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_kind == K_DATA_EXCL) |-> (out_inv_cnt == CNT_W'($countones(out_inv_mask))));

    // R10: mask and count are empty outside exclusive data
    a_r10_no_mask_elsewhere: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_kind != K_DATA_EXCL) |-> (out_inv_mask == '0 && out_inv_cnt == '0));

    // R1: nothing is accepted before the sweep ends
    a_r1_quiet_during_init: assert property (@(posedge clk) disable iff (rst)
        !in_ready |=> !out_valid);

endmodule

// File: tb/coh_dir_engine_tb.sv
`timescale 1ns/1ps
module coh_dir_engine_tb_top;
    localparam int IDX_W  = 3;
    localparam int HOME   = 3;
    localparam int DEPTH  = 1 << IDX_W;
    localparam int ADDR_W = 8 + IDX_W;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              in_valid = 1'b0;
    logic              in_ready;
    logic [1:0]        in_op = '0;
    logic [ADDR_W-1:0] in_addr = '0;
    logic [3:0]        in_src = '0;
    logic              out_valid;
    logic [2:0]        out_kind;
    logic [3:0]        out_dest;
    logic [3:0]        out_src;
    logic [ADDR_W-5:0] out_line;
    logic [15:0]       out_inv_mask;
    logic [4:0]        out_inv_cnt;

    int nchk  = 0;
    int nfail = 0;

    logic [15:0] m_pres [DEPTH];
    logic        m_dirty [DEPTH];

    always #10 clk = ~clk;

    coh_dir_engine #(.IDX_W(IDX_W), .HOME_ID(HOME)) dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_op(in_op), .in_addr(in_addr), .in_src(in_src),
        .out_valid(out_valid), .out_kind(out_kind), .out_dest(out_dest),
        .out_src(out_src), .out_line(out_line), .out_inv_mask(out_inv_mask),
        .out_inv_cnt(out_inv_cnt)
    );

    task automatic chk(input string tag, input string what, input int got, input int exp);
        nchk++;
        if (got != exp) begin
            nfail++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
        end
    endtask

    function automatic int owner_of(input logic [15:0] p);
        for (int i = 0; i < 16; i++) if (p[i]) return i;
        return 0;
    endfunction

    function automatic int ones(input logic [15:0] p);
        int n = 0;
        for (int i = 0; i < 16; i++) n += int'(p[i]);
        return n;
    endfunction

    // Drive a request at a falling edge and check the message one cycle later
    task automatic issue(input int op, input int idx, input int home, input int src, input int ofs);
        int          e_kind, e_dest, e_cnt;
        logic [15:0] e_mask;
        logic [15:0] rb;
        string       tag;
        int          own;
        logic        dty;
        int          line;
        line = (idx << 4) | home;
        in_valid = 1'b1;
        in_op    = 2'(op);
        in_src   = 4'(src);
        in_addr  = ADDR_W'((line << 4) | ofs);
        e_kind = 4; e_dest = src; e_mask = '0; e_cnt = 0; tag = "R8";
        if (home == HOME) begin
            rb  = 16'(1) << src;
            dty = m_dirty[idx];
            own = owner_of(m_pres[idx]);
            if (op == 0) begin
                if (!dty) begin
                    e_kind = 0; tag = "R3"; m_pres[idx] |= rb;
                end else if (own != src) begin
                    e_kind = 2; e_dest = own; tag = "R5";
                    m_pres[idx] |= rb; m_dirty[idx] = 1'b0;
                end
            end else if (op == 1) begin
                if (!dty) begin
                    e_kind = 1; tag = "R4";
                    e_mask = m_pres[idx] & ~rb; e_cnt = ones(e_mask);
                    m_pres[idx] = rb; m_dirty[idx] = 1'b1;
                end else if (own != src) begin
                    e_kind = 2; e_dest = own; tag = "R6";
                    m_pres[idx] = rb; m_dirty[idx] = 1'b1;
                end
            end else if (op == 2) begin
                if (dty && own == src) begin
                    e_kind = 3; tag = "R7";
                    m_pres[idx] = '0; m_dirty[idx] = 1'b0;
                end
            end
        end
        @(posedge clk);
        @(negedge clk);
        if (home == HOME) begin
            chk("R9", "out_valid", int'(out_valid), 1);
            chk(tag, "kind", int'(out_kind), e_kind);
            chk(tag, "dest", int'(out_dest), e_dest);
            chk(tag, "inv_mask", int'(out_inv_mask), int'(e_mask));
            chk(tag, "inv_cnt", int'(out_inv_cnt), e_cnt);
            chk("R10", "src", int'(out_src), src);
            chk("R10", "line", int'(out_line), line);
        end else begin
            chk("R2", "foreign out_valid", int'(out_valid), 0);
        end
    endtask

    task automatic idle();
        in_valid = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk("R9", "idle out_valid", int'(out_valid), 0);
    endtask

    initial begin : watchdog
        #(20 * 200000);
        nchk++;
        nfail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin : main
        int unsigned r;
        int op, idx, home, src;
        for (int i = 0; i < DEPTH; i++) begin
            m_pres[i] = '0; m_dirty[i] = 1'b0;
        end
        repeat (3) @(negedge clk);
        chk("R1", "ready in reset", int'(in_ready), 0);
        // Hold a home writeback pending through the sweep: it must not be taken
        in_valid = 1'b1; in_op = 2'd2; in_src = 4'd1;
        in_addr  = ADDR_W'((HOME << 4));
        rst = 1'b0;
        for (int k = 1; k <= DEPTH; k++) begin
            @(posedge clk);
            @(negedge clk);
            chk("R1", "ready during sweep", int'(in_ready), (k >= DEPTH) ? 1 : 0);
            chk("R1", "out_valid during sweep", int'(out_valid), 0);
        end
        idle();

        // Directed sequence on entry 0, issued back to back
        issue(0, 0, HOME, 1, 0);
        issue(0, 0, HOME, 2, 5);
        issue(0, 0, HOME, 7, 15);
        issue(1, 0, HOME, 2, 0);    // R4: invalidates 1 and 7
        issue(0, 0, HOME, 9, 0);    // R5: forward to 2
        issue(1, 0, HOME, 4, 0);    // R4: invalidates 2 and 9
        issue(1, 0, HOME, 11, 0);   // R6: forward to 4
        issue(2, 0, HOME, 4, 0);    // R8: not owner
        issue(0, 0, HOME, 11, 0);   // R8: owner reads own line
        issue(2, 0, HOME, 11, 0);   // R7
        issue(2, 0, HOME, 11, 0);   // R8: clean line
        issue(0, 0, HOME, 11, 0);
        issue(1, 0, HOME, 11, 0);   // R4: sole sharer, empty mask
        issue(3, 0, HOME, 5, 0);    // R8: reserved op
        issue(1, 0, (HOME + 1) % 16, 5, 0); // R2: foreign home ignored
        issue(1, 0, HOME, 5, 0);    // R6: forward to 11, entry untouched by foreign
        idle();

        // Build wide sharer sets on every entry, then claim each exclusively
        for (int e = 0; e < DEPTH; e++) begin
            for (int s = 0; s < 16; s++) issue(0, e, HOME, s, s);
            issue(1, e, HOME, e, 0);
        end
        idle();

        // Pseudo-random sweep over all clusters and entries
        r = 32'h1234_5678;
        for (int n = 0; n < 4000; n++) begin
            r ^= r << 13; r ^= r >> 17; r ^= r << 5;
            idx  = int'(r % DEPTH);
            src  = int'((r >> 4) % 16);
            case ((r >> 8) % 8)
                0, 1, 2: op = 0;
                3, 4, 5: op = 1;
                6:       op = 2;
                default: op = (((r >> 11) % 4) == 0) ? 3 : 2;
            endcase
            if (op == 2 && m_dirty[idx] && ((r >> 13) % 4 != 0)) src = owner_of(m_pres[idx]);
            home = (((r >> 16) % 8) == 0) ? int'((r >> 20) % 16) : HOME;
            issue(op, idx, home, src, int'((r >> 24) % 16));
            if (((r >> 27) % 16) == 0) idle();
        end
        idle();

        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

endmodule